// File: doc/BRIEF.md
# Sigma-Delta Bitstream Capture

This block takes the one-bit serial stream of an external delta-sigma modulator and turns it into a bit value plus a one-cycle valid strobe in the system clock domain. The link has only two wires: a clock and a data line. Nothing travels from the receiver to the modulator except the clock in one of the two options, and there is no select line.

Two options are chosen by a mode input that is latched only while reset is held. In driven mode the block divides the system clock to produce the modulator clock. The modulator then holds each output bit for two cycles of that clock. The block works out from the data alone which of the two clock phases carries the settled copy, and it emits one bit per pair. In free-running mode the modulator supplies its own clock. Clock and data pass through a synchronizer, and each rising edge of the synchronized clock yields one captured bit.

Decimation, filtering and the analog front end sit elsewhere. A downstream decimator consumes `bit_out` whenever `bit_valid` is high.

Top module: `sdm_capture`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bit_valid`, `bit_out` and `mod_clk_out` are 0.
- R2: In driven mode (`mode_free` = 0 at reset), `mod_clk_out` is a square wave that stays high for DIV_HALF system cycles and low for DIV_HALF system cycles.
- R3: In driven mode, no `bit_valid` pulse appears before the first WIN modulator clock cycles after reset have been observed (the lock window).
- R4: In driven mode, after lock there is exactly one `bit_valid` per two-cycle modulator bit, whichever pair alignment the modulator uses. The pulse follows the falling edge of the second clock cycle of that bit, and `bit_out` equals the bit. The lock selects the sampling phase on which the data changed less often during the window.
- R5: In free-running mode (`mode_free` = 1 at reset), each rising edge on `mod_clk_in` produces exactly one `bit_valid` pulse. `bit_out` carries the `mod_data_in` level present at that edge, and the bits come out in arrival order.
- R6: `bit_valid` is never high in two consecutive system cycles.
- R7: A change of `mode_free` while `rst` is low has no effect. Capture continues in the mode latched during reset.
- R8: In free-running mode `mod_clk_out` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; mode is latched while high |
| mode_free | input | 1 | 0 = block drives modulator clock, 1 = modulator clock is free-running |
| mod_clk_out | output | 1 | Divided clock to the modulator (driven mode) |
| mod_clk_in | input | 1 | Modulator's own clock (free-running mode), asynchronous |
| mod_data_in | input | 1 | Modulator bitstream |
| bit_out | output | 1 | Captured bit |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
Driven mode is run twice with a pseudo-random bitstream. In one run the modulator starts new bits on even clock cycles, and in the other on odd ones. Only correct phase selection gives both the right values and emission on the second cycle of every bit. A wrong lock shows up as pulses on the first cycle or as early pulses inside the window. Free-running mode uses a modulator clock that is not an integer multiple of the system clock, with data changing away from its rising edge. This exposes lost, doubled or misordered bits through the synchronizer. Halfway through that run the mode input is flipped, to show that the latched mode governs.

// File: rtl/sdm_pkg.sv
`timescale 1ns/1ps
package sdm_pkg;
  typedef enum logic {
    MODE_DRIVEN = 1'b0,
    MODE_FREE   = 1'b1
  } sdm_mode_e;
endpackage

// File: rtl/sdm_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for asynchronous inputs.
module sdm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [WIDTH-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= g_stage[i-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/sdm_clkdiv.sv
`timescale 1ns/1ps
// Divides the system clock into the modulator clock; flags the edge at
// which the divided clock falls, the point where data is sampled.
module sdm_clkdiv #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic clk_out,
  output logic fall_stb
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          clk_q;
  logic          term;

  assign term = (cnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      clk_q <= 1'b0;
    end else if (term) begin
      cnt   <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clk_out  = clk_q;
  assign fall_stb = en && term && clk_q;
endmodule

// File: rtl/sdm_phase_lock.sv
`timescale 1ns/1ps
// Counts data changes per sampling phase over a window of samples and
// selects the phase that changes least; passes samples of that phase.
module sdm_phase_lock #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic din,
  output logic out_stb,
  output logic out_bit
);
  localparam int CW = $clog2(WIN + 1);
  localparam int IW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          phase;
  logic          last_bit;
  logic          locked;
  logic          sel;
  logic [CW-1:0] cnt_p0;
  logic [CW-1:0] cnt_p1;
  logic [IW-1:0] widx;
  logic          chg;
  logic [CW-1:0] n0;
  logic [CW-1:0] n1;
  logic          win_end;

  always_comb begin
    chg     = din ^ last_bit;
    n0      = cnt_p0 + CW'(chg && !phase);
    n1      = cnt_p1 + CW'(chg && phase);
    win_end = (widx == IW'(WIN - 1));
    out_stb = stb && locked && (phase == sel);
    out_bit = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      last_bit <= 1'b0;
      locked   <= 1'b0;
      sel      <= 1'b0;
      cnt_p0   <= '0;
      cnt_p1   <= '0;
      widx     <= '0;
    end else if (stb) begin
      last_bit <= din;
      phase    <= ~phase;
      if (win_end) begin
        widx   <= '0;
        cnt_p0 <= '0;
        cnt_p1 <= '0;
        if (n0 < n1) begin
          sel    <= 1'b0;
          locked <= 1'b1;
        end else if (n1 < n0) begin
          sel    <= 1'b1;
          locked <= 1'b1;
        end
      end else begin
        widx   <= widx + 1'b1;
        cnt_p0 <= n0;
        cnt_p1 <= n1;
      end
    end
  end
endmodule

// File: rtl/sdm_capture.sv
`timescale 1ns/1ps
module sdm_capture
  import sdm_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int WIN         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_free,
  output logic mod_clk_out,
  input  logic mod_clk_in,
  input  logic mod_data_in,
  output logic bit_out,
  output logic bit_valid
);
  sdm_mode_e mode_q;
  logic      fall_stb;
  logic      lock_stb;
  logic      lock_bit;
  logic [1:0] syn;
  logic      clk_d;
  logic      free_rise;

  // Mode is only taken while reset is held.
  always_ff @(posedge clk) begin
    if (rst) mode_q <= sdm_mode_e'(mode_free);
  end

  sdm_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
    .clk      (clk),
    .rst      (rst),
    .en       (mode_q == MODE_DRIVEN),
    .clk_out  (mod_clk_out),
    .fall_stb (fall_stb)
  );

  sdm_phase_lock #(.WIN(WIN)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .stb     (fall_stb),
    .din     (mod_data_in),
    .out_stb (lock_stb),
    .out_bit (lock_bit)
  );

  sdm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({mod_clk_in, mod_data_in}),
    .q   (syn)
  );

  always_ff @(posedge clk) begin
    if (rst) clk_d <= 1'b0;
    else     clk_d <= syn[1];
  end

  assign free_rise = syn[1] && !clk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else if (mode_q == MODE_FREE) begin
      bit_valid <= free_rise;
      if (free_rise) bit_out <= syn[0];
    end else begin
      bit_valid <= lock_stb;
      if (lock_stb) bit_out <= lock_bit;
    end
  end
endmodule

// File: rtl/sdm_capture_chk.sv
`timescale 1ns/1ps
module sdm_capture_chk #(
  parameter int DIV_HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic mode_lat,
  input logic mod_clk_out,
  input logic bit_valid,
  input logic bit_out
);
  localparam int RW = $clog2(DIV_HALF + 2) + 1;

  logic          prev_clk;
  logic [RW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_clk <= 1'b0;
      run      <= '0;
    end else begin
      prev_clk <= mod_clk_out;
      if (mod_clk_out != prev_clk)          run <= RW'(1);
      else if (run <= RW'(DIV_HALF))        run <= run + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bit_valid && !bit_out && !mod_clk_out)); // R1

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (!mode_lat && (mod_clk_out != prev_clk)) |-> (run == RW'(DIV_HALF))); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid); // R6

  AST_FREE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    mode_lat |-> !mod_clk_out); // R8
endmodule

bind sdm_capture sdm_capture_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_lat    (mode_q),
  .mod_clk_out (mod_clk_out),
  .bit_valid   (bit_valid),
  .bit_out     (bit_out)
);

// File: tb/sdm_capture_bench.sv
`timescale 1ns/1ps
module sdm_capture_bench;
  localparam int DIV_HALF = 2;
  localparam int WIN      = 16;
  localparam int NFREE    = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_free = 1'b0;
  logic mod_clk_in = 1'b0;
  logic mod_data_in = 1'b0;
  logic mod_clk_out;
  logic bit_out;
  logic bit_valid;

  int checks = 0;
  int errors = 0;
  bit exp_q[$];
  bit drv_on = 1'b0;
  bit free_run = 1'b0;
  int off = 0;
  int rise_k = 0;
  int age = 1;
  int bit_n = 0;
  int emitted = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_valid = 1'b0;

  sdm_capture #(.DIV_HALF(DIV_HALF), .WIN(WIN)) u_sdm_capture (
    .clk         (clk),
    .rst         (rst),
    .mode_free   (mode_free),
    .mod_clk_out (mod_clk_out),
    .mod_clk_in  (mod_clk_in),
    .mod_data_in (mod_data_in),
    .bit_out     (bit_out),
    .bit_valid   (bit_valid)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit gen_bit();
    bit b;
    if (bit_n == 0)      b = 1'b1;
    else if (bit_n == 1) b = 1'b0;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      b = lfsr[0];
    end
    bit_n++;
    return b;
  endfunction

  // Modulator model for driven mode: a new bit every second clock.
  always @(posedge mod_clk_out) begin
    if (drv_on && !rst) begin
      if (rise_k % 2 == off) begin
        #1 mod_data_in = gen_bit();
        age = 0;
      end else begin
        age++;
      end
      if (rise_k >= WIN && age == 1) exp_q.push_back(mod_data_in);
      rise_k++;
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst) begin
      if (bit_valid) begin
        emitted++;
        if (exp_q.size() == 0) begin
          check(1'b0, free_run ? "R5 pulse with nothing pending" : "R4 pulse with nothing pending", 1, 0);
        end else begin
          bit b;
          b = exp_q.pop_front();
          check(bit_out == b, free_run ? "R5 bit value" : "R4 bit value", int'(bit_out), int'(b));
        end
        if (!free_run) begin
          check(rise_k > WIN, "R3 pulse inside lock window", rise_k, WIN + 1);
          check(age == 1, "R4 pulse on second clock of bit", age, 1);
        end
        check(!prev_valid, "R6 back-to-back valid", int'(prev_valid), 0);
      end
      if (free_run) check(mod_clk_out == 1'b0, "R8 clock output idle", int'(mod_clk_out), 0);
    end
    prev_valid <= bit_valid;
  end

  task automatic do_reset(input bit mode);
    rst = 1'b1;
    mode_free = mode;
    repeat (4) begin
      @(negedge clk);
      check(bit_valid == 1'b0, "R1 valid in reset", int'(bit_valid), 0);
      check(mod_clk_out == 1'b0, "R1 clock in reset", int'(mod_clk_out), 0);
    end
    check(bit_out == 1'b0, "R1 data in reset", int'(bit_out), 0);
    exp_q.delete();
    rise_k = 0;
    age = 1;
    bit_n = 0;
    emitted = 0;
    mod_data_in = 1'b0;
    mod_clk_in = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(bit_valid == 1'b0 && bit_out == 1'b0, "R1 first cycle after reset", int'(bit_valid), 0);
  endtask

  task automatic measure_div();
    int hi;
    int lo;
    while (mod_clk_out != 1'b1) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      hi = 0;
      while (mod_clk_out == 1'b1) begin hi++; @(negedge clk); end
      check(hi == DIV_HALF, "R2 high time", hi, DIV_HALF);
      lo = 0;
      while (mod_clk_out == 1'b0) begin lo++; @(negedge clk); end
      check(lo == DIV_HALF, "R2 low time", lo, DIV_HALF);
    end
  endtask

  task automatic driven_run(input int alignment, input logic [15:0] seed);
    off = alignment;
    lfsr = seed;
    free_run = 1'b0;
    drv_on = 1'b1;
    do_reset(1'b0);
    measure_div();
    wait (rise_k >= WIN + 80);
    @(negedge clk);
    check(emitted >= 38, "R4 bits emitted", emitted, 38);
    check(exp_q.size() <= 1, "R4 bits left unemitted", exp_q.size(), 1);
    drv_on = 1'b0;
    rst = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    driven_run(0, 16'hACE1);
    driven_run(1, 16'h1D2B);

    // Free-running mode.
    lfsr = 16'h5A5A;
    do_reset(1'b1);
    free_run = 1'b1;
    #3;
    for (int n = 0; n < NFREE; n++) begin
      if (n == NFREE / 2) mode_free = 1'b0;  // R7: ignored while running
      mod_data_in = gen_bit();
      #17 mod_clk_in = 1'b1;
      exp_q.push_back(mod_data_in);
      #35 mod_clk_in = 1'b0;
      #18;
    end
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5 bits left unemitted", exp_q.size(), 0);
    check(emitted == NFREE, "R7 capture continued after mode input change", emitted, NFREE);
    free_run = 1'b0;
    rst = 1'b1;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule